// File: doc/BRIEF.md
# Inter-Processor Mailbox with Per-User Interrupts

A register-mapped mailbox through which several processors ("users") pass 32-bit words to one another. It holds a parameterized number of small first-in first-out message queues. A processor sends by writing a queue's message register, which enqueues the word. The receiver takes the oldest word by reading the same register, which dequeues it. For each queue, a full-status register and a message-count register let software poll the queue's state.

Every user has its own interrupt status register, interrupt enable register and interrupt output. Each queue drives two event bits into every user's status register: "holds a message" and "has room". A user acknowledges an event by writing 1 to its bit. The user's interrupt line is high while any enabled status bit is set. A build parameter selects one of two interrupt register layouts. In the compact layout, software disables interrupts by rewriting the enable register. The other layout adds a separate register that clears enable bits.

The bus is a plain single-cycle register interface with no back-pressure. Every access completes in the cycle its strobe is sampled. Read data is registered and appears one cycle after the read strobe. A push into a full queue is dropped, and a pop from an empty queue returns 0. Software avoids both by checking the status registers first.

Top module: `ipc_mailbox`

## Requirements
- R1: Writing the message register of queue m (byte offset 0x040 + 4*m) enqueues the write data. Reading it returns and removes the oldest word, so words leave each queue in the order they were written.
- R2: A write to a full queue is dropped: its count and contents stay unchanged. A read of an empty queue's message register returns 0 and leaves the queue unchanged.
- R3: Offset 0x080 + 4*m reads 1 when queue m holds DEPTH words and 0 otherwise. Offset 0x0C0 + 4*m reads the number of words in queue m. Neither register changes on a write.
- R4: In every user's status register, bit 2*m becomes 1 while queue m is non-empty and bit 2*m+1 becomes 1 while queue m is not full. A bit is set on the clock edge after the queue state that causes it. Bits at and above 2*NQ read 0.
- R5: Writing 1 to a status bit clears it, and status bits written with 0 keep their value. If the condition for a cleared bit still holds, the bit is set again one cycle later. A read issued in the cycle right after the acknowledging write therefore returns the bit as 0.
- R6: Interrupt output u is high exactly when the bitwise AND of user u's enable and status registers is non-zero.
- R7: With LAYOUT=0, user u's status register is at 0x100 + 8*u and its enable register is at 0x104 + 8*u. A write to the enable register replaces its whole value.
- R8: With LAYOUT=1, user u's status register is at 0x104 + 0x10*u, its enable register is at 0x108 + 0x10*u and its enable-clear register is at 0x10C + 0x10*u. Writing 1s to the enable register sets those enable bits. Writing 1s to the enable-clear register clears those enable bits. Writing 0 bits to either register has no effect. Both registers read back the enable value.
- R9: Offset 0x000 reads the read-only parameter REV (default 0x00030100), and a write to it changes nothing. Unmapped offsets read 0. Read data appears on bus_rdata one cycle after the read strobe and holds until the next read.
- R10: After reset all queues are empty, all status and enable bits are 0, every interrupt output is low and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | AW (9) | Byte offset of the access |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| irq_o | output | NU (4) | One interrupt line per user |

## Verification
Assertions check on every cycle that no queue count exceeds its depth. They also check that a push into a queue with room adds exactly one word, and that a push into a full queue or a pop from an empty one changes nothing. Further assertions check that an empty pop returns 0, that the revision register reads back its parameter, and that a full disable or clear write drops the user's interrupt on the next cycle. Only the bench's scenarios can show end-to-end message ordering under random traffic. The same holds for the one-cycle gap and re-set after acknowledging a still-true event, the set-versus-replace enable semantics of the two layouts, and an event reaching every user's status register.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

  // Byte offsets of the per-queue registers.
  function automatic logic [31:0] msg_off(input int m);
    return 32'h040 + 32'(4 * m);
  endfunction

  function automatic logic [31:0] full_off(input int m);
    return 32'h080 + 32'(4 * m);
  endfunction

  function automatic logic [31:0] cnt_off(input int m);
    return 32'h0C0 + 32'(4 * m);
  endfunction

  // Byte offsets of the per-user interrupt registers; lay selects the layout.
  function automatic logic [31:0] sts_off(input int lay, input int u);
    return (lay != 0) ? 32'h104 + 32'(16 * u) : 32'h100 + 32'(8 * u);
  endfunction

  function automatic logic [31:0] en_off(input int lay, input int u);
    return (lay != 0) ? 32'h108 + 32'(16 * u) : 32'h104 + 32'(8 * u);
  endfunction

  function automatic logic [31:0] clr_off(input int u);
    return 32'h10C + 32'(16 * u);
  endfunction

endpackage

// File: rtl/ipc_mbx_queue.sv
module ipc_mbx_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push_i,
  input  logic                           pop_i,
  input  logic [DW-1:0]                  wdata_i,
  output logic [DW-1:0]                  head_o,
  output logic [$clog2(DEPTH+1)-1:0]     cnt_o,
  output logic                           full_o,
  output logic                           empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= step(wr_ptr);
      if (pop_i)  rd_ptr <= step(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // Storage carries no reset; the count alone qualifies its contents.
  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= wdata_i;
  end

  assign head_o  = mem[rd_ptr];
  assign cnt_o   = cnt;
  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
endmodule

// File: rtl/ipc_mbx_user.sv
module ipc_mbx_user #(
  parameter int IW     = 8,
  parameter int LAYOUT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] evt_i,
  input  logic          ack_i,
  input  logic          en_wr_i,
  input  logic          en_clr_i,
  input  logic [IW-1:0] wdata_i,
  output logic [IW-1:0] sts_o,
  output logic [IW-1:0] en_o,
  output logic          irq_o
);
  logic [IW-1:0] sts, en, ack_mask, en_nxt;

  assign ack_mask = ack_i ? wdata_i : '0;

  // An acknowledged bit stays clear for one cycle even if its event persists.
  always_comb begin
    en_nxt = en;
    if (en_wr_i)  en_nxt = (LAYOUT != 0) ? (en | wdata_i) : wdata_i;
    if (en_clr_i) en_nxt = en & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= (sts & ~ack_mask) | (evt_i & ~ack_mask);
      en  <= en_nxt;
    end
  end

  assign sts_o = sts;
  assign en_o  = en;
  assign irq_o = |(sts & en);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbx_pkg::*;
#(
  parameter int          NQ     = 4,
  parameter int          DEPTH  = 4,
  parameter int          NU     = 4,
  parameter int          DW     = 32,
  parameter int          AW     = 9,
  parameter int          LAYOUT = 1,
  parameter logic [31:0] REV    = 32'h0003_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NU-1:0] irq_o
);
  localparam int IW = 2 * NQ;
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]                addr32;
  logic [NQ-1:0][DW-1:0]      q_head;
  logic [NQ-1:0][CW-1:0]      q_cnt;
  logic [NQ-1:0]              q_full, q_empty, q_push, q_pop;
  logic [IW-1:0]              evt;
  logic [NU-1:0][IW-1:0]      u_sts, u_en;
  logic [DW-1:0]              rd_mux;

  assign addr32 = 32'(bus_addr);

  for (genvar m = 0; m < NQ; m++) begin : g_q
    assign q_push[m] = bus_wr && (addr32 == msg_off(m)) && !q_full[m];
    assign q_pop[m]  = bus_rd && (addr32 == msg_off(m)) && !q_empty[m];
    assign evt[2*m]   = !q_empty[m];
    assign evt[2*m+1] = !q_full[m];

    ipc_mbx_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (q_push[m]),
      .pop_i   (q_pop[m]),
      .wdata_i (bus_wdata),
      .head_o  (q_head[m]),
      .cnt_o   (q_cnt[m]),
      .full_o  (q_full[m]),
      .empty_o (q_empty[m])
    );
  end

  for (genvar u = 0; u < NU; u++) begin : g_u
    logic ack, en_wr, en_clr;
    assign ack   = bus_wr && (addr32 == sts_off(LAYOUT, u));
    assign en_wr = bus_wr && (addr32 == en_off(LAYOUT, u));
    if (LAYOUT != 0) begin : g_clr
      assign en_clr = bus_wr && (addr32 == clr_off(u));
    end else begin : g_noclr
      assign en_clr = 1'b0;
    end

    ipc_mbx_user #(.IW(IW), .LAYOUT(LAYOUT)) u_user (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt),
      .ack_i    (ack),
      .en_wr_i  (en_wr),
      .en_clr_i (en_clr),
      .wdata_i  (bus_wdata[IW-1:0]),
      .sts_o    (u_sts[u]),
      .en_o     (u_en[u]),
      .irq_o    (irq_o[u])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr32 == 32'h0) rd_mux = DW'(REV);
    for (int m = 0; m < NQ; m++) begin
      if (addr32 == msg_off(m))  rd_mux = q_empty[m] ? '0 : q_head[m];
      if (addr32 == full_off(m)) rd_mux = DW'(q_full[m]);
      if (addr32 == cnt_off(m))  rd_mux = DW'(q_cnt[m]);
    end
    for (int u = 0; u < NU; u++) begin
      if (addr32 == sts_off(LAYOUT, u)) rd_mux = DW'(u_sts[u]);
      if (addr32 == en_off(LAYOUT, u))  rd_mux = DW'(u_en[u]);
      if (LAYOUT != 0 && addr32 == clr_off(u)) rd_mux = DW'(u_en[u]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
  import ipc_mbx_pkg::*;
#(
  parameter int          NQ     = 4,
  parameter int          DEPTH  = 4,
  parameter int          NU     = 4,
  parameter int          DW     = 32,
  parameter int          AW     = 9,
  parameter int          LAYOUT = 1,
  parameter logic [31:0] REV    = 32'h0003_0100
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  bus_wr,
  input logic                                  bus_rd,
  input logic [AW-1:0]                         bus_addr,
  input logic [2*NQ-1:0]                       bus_wdata,
  input logic [DW-1:0]                         bus_rdata,
  input logic [NU-1:0]                         irq_o,
  input logic [NQ-1:0][$clog2(DEPTH+1)-1:0]    q_cnt,
  input logic [NQ-1:0]                         q_full
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [31:0] a32;
  assign a32 = 32'(bus_addr);

  // R9
  rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && a32 == 32'h0 |=> bus_rdata == DW'(REV));

  for (genvar m = 0; m < NQ; m++) begin : g_qchk
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt[m] <= CW'(DEPTH));
    // R1
    push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && a32 == msg_off(m) && !q_full[m] |=> q_cnt[m] == CW'($past(q_cnt[m]) + 1'b1));
    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && a32 == msg_off(m) && q_full[m] |=> $stable(q_cnt[m]));
    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && a32 == msg_off(m) && q_cnt[m] == '0 |=> bus_rdata == '0 && $stable(q_cnt[m]));
  end

  for (genvar u = 0; u < NU; u++) begin : g_uchk
    if (LAYOUT != 0) begin : g_l1
      // R8
      clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && a32 == clr_off(u) && bus_wdata == '1 |=> !irq_o[u]);
    end else begin : g_l0
      // R7
      en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && a32 == en_off(0, u) && bus_wdata == '0 |=> !irq_o[u]);
    end
  end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .NQ(NQ), .DEPTH(DEPTH), .NU(NU), .DW(DW), .AW(AW), .LAYOUT(LAYOUT), .REV(REV)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata[2*NQ-1:0]),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .q_cnt     (q_cnt),
  .q_full    (q_full)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  localparam int NQ = 4, DEPTH = 4, NU = 4;
  localparam logic [31:0] REV = 32'h0003_0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, tgt = 1'b1;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, rdata1, rdata0;
  logic [NU-1:0] irq1, irq0;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] mq [NQ][$];

  always #4 clk = ~clk;

  ipc_mailbox #(.LAYOUT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr & tgt), .bus_rd(bus_rd & tgt),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1), .irq_o(irq1));

  ipc_mailbox #(.LAYOUT(0)) u_dut_l0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr & ~tgt), .bus_rd(bus_rd & ~tgt),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0), .irq_o(irq0));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = tgt ? rdata1 : rdata0;
  endtask

  function automatic logic [8:0] a_msg(input int q);  return 9'(32'h40 + 4*q); endfunction
  function automatic logic [8:0] a_full(input int q); return 9'(32'h80 + 4*q); endfunction
  function automatic logic [8:0] a_cnt(input int q);  return 9'(32'hC0 + 4*q); endfunction
  function automatic logic [8:0] a_sts1(input int u); return 9'(32'h104 + 16*u); endfunction
  function automatic logic [8:0] a_en1(input int u);  return 9'(32'h108 + 16*u); endfunction
  function automatic logic [8:0] a_clr1(input int u); return 9'(32'h10C + 16*u); endfunction
  function automatic logic [8:0] a_sts0(input int u); return 9'(32'h100 + 8*u); endfunction
  function automatic logic [8:0] a_en0(input int u);  return 9'(32'h104 + 8*u); endfunction

  // Expected status bits from the model queues.
  function automatic logic [31:0] exp_events();
    logic [31:0] e = '0;
    for (int m = 0; m < NQ; m++) begin
      e[2*m]   = (mq[m].size() != 0);
      e[2*m+1] = (mq[m].size() < DEPTH);
    end
    return e;
  endfunction

  task automatic push1(input int q, input logic [31:0] d);
    bus_write(a_msg(q), d);
    if (mq[q].size() < DEPTH) mq[q].push_back(d);
  endtask

  task automatic pop1(input int q, input string tag);
    logic [31:0] got, exp;
    bus_read(a_msg(q), got);
    exp = (mq[q].size() != 0) ? mq[q].pop_front() : 32'h0;
    check(tag, got, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd715));
    idle(3);
    check("R10 irq after reset", 32'(irq1), 32'h0);
    check("R10 rdata after reset", rdata1, 32'h0);
    rst_n = 1'b1;
    idle(1);
    // R9 revision, write ignored, unmapped
    bus_read(9'h000, d); check("R9 revision", d, REV);
    bus_write(9'h000, 32'hFFFF_FFFF);
    bus_read(9'h000, d); check("R9 revision read-only", d, REV);
    bus_read(9'h1F0, d); check("R9 unmapped reads 0", d, 32'h0);
    idle(2);
    // R4 reset events at every user
    bus_read(a_sts1(0), d); check("R4 status user0", d, exp_events());
    bus_read(a_sts1(3), d); check("R4 status user3", d, exp_events());
    // R8 enable set, R6 no irq with empty queue
    bus_write(a_en1(2), 32'h4);
    bus_read(a_en1(2), d); check("R8 enable readback", d, 32'h4);
    check("R6 irq idle", 32'(irq1), 32'h0);
    push1(1, 32'h1111_2222);
    idle(2);
    check("R6 irq user2 only", 32'(irq1), 32'h4);
    bus_read(a_sts1(2), d); check("R4 newmsg status", d, exp_events());
    // R5 ack, then re-set while message remains
    bus_write(a_sts1(2), 32'h4);
    bus_read(a_sts1(2), d); check("R5 cleared in next cycle", d, exp_events() & ~32'h4);
    bus_read(a_sts1(2), d); check("R5 re-set while pending", d, exp_events());
    pop1(1, "R1 pop word");
    idle(2);
    bus_write(a_sts1(2), 32'hFF);
    idle(2);
    bus_read(a_sts1(2), d); check("R5 ack all", d, exp_events());
    check("R6 irq dropped", 32'(irq1), 32'h0);
    // R8 set/clear semantics
    bus_write(a_en1(2), 32'h3);
    bus_read(a_en1(2), d); check("R8 set ORs", d, 32'h7);
    bus_write(a_clr1(2), 32'h0);
    bus_read(a_en1(2), d); check("R8 clear zero no effect", d, 32'h7);
    bus_write(a_clr1(2), 32'h5);
    bus_read(a_clr1(2), d); check("R8 clear ones", d, 32'h2);
    bus_write(a_clr1(2), 32'hFF);
    // R3/R2 full queue
    for (int i = 0; i < DEPTH; i++) push1(0, 32'hA000_0000 + 32'(i));
    bus_read(a_full(0), d); check("R3 full flag", d, 32'h1);
    bus_read(a_cnt(0), d); check("R3 count full", d, 32'(DEPTH));
    push1(0, 32'hDEAD_BEEF);
    bus_read(a_cnt(0), d); check("R2 full write dropped", d, 32'(DEPTH));
    bus_write(a_sts1(0), 32'hFF);
    idle(2);
    bus_read(a_sts1(0), d); check("R4 not-full cleared when full", d, exp_events());
    for (int i = 0; i <= DEPTH; i++) pop1(0, "R1 R2 drain order");
    bus_read(a_cnt(0), d); check("R2 empty pop unchanged", d, 32'h0);
    bus_read(a_full(0), d); check("R3 not full", d, 32'h0);
    // R7 compact layout
    tgt = 1'b0;
    bus_read(9'h000, d); check("R9 revision layout0", d, REV);
    bus_read(a_sts0(1), d); check("R7 status user1", d, 32'hAA);
    bus_write(a_en0(1), 32'h3);
    bus_read(a_en0(1), d); check("R7 enable", d, 32'h3);
    bus_write(a_en0(1), 32'h1);
    bus_read(a_en0(1), d); check("R7 enable replaced", d, 32'h1);
    check("R7 irq idle", 32'(irq0), 32'h0);
    bus_write(a_msg(0), 32'h55);
    idle(2);
    check("R7 irq user1", 32'(irq0), 32'h2);
    bus_write(a_en0(1), 32'h0);
    check("R7 irq off after rewrite", 32'(irq0), 32'h0);
    tgt = 1'b1;
    // R1/R2/R3 random traffic against model
    for (int i = 0; i < 400; i++) begin
      int q, op;
      q = int'($urandom % NQ);
      op = int'($urandom % 4);
      case (op)
        0, 1: push1(q, $urandom);
        2: pop1(q, "R1 random pop");
        default: begin
          bus_read(a_cnt(q), d); check("R3 random count", d, 32'(mq[q].size()));
          bus_read(a_full(q), d); check("R3 random full", d, 32'(mq[q].size() == DEPTH));
        end
      endcase
    end
    bus_write(a_sts1(1), 32'hFF);
    idle(2);
    bus_read(a_sts1(1), d); check("R4 final status user1", d, exp_events());
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule